// File: doc/BRIEF.md
# Dual-Source 16x16 Multiply-Accumulate Unit

This unit sits beside a 32-bit processor pipeline as a multiply-accumulate coprocessor. It keeps four 32-bit kernel registers (K0 to K3) and one 40-bit accumulator. Every command arrives in a single cycle. The command carries an opcode, two operand words from the general register file, source and half-word selects for each operand, and the fields needed for a kernel-register load. Each multiply takes one 16-bit half from each operand. The first operand comes from a general register or from K0/K1. The second comes from a general register or from K2/K3. The product either replaces the accumulator, is added to it, or is subtracted from it.

A load command copies a word from a single-cycle memory read port into one kernel register. In the same cycle the unit returns the address stepped by four bytes up or down, so the pipeline can write it back to the address register. A combined command performs a signed multiply-accumulate and a kernel load together. When both touch the same kernel register, the multiply sees the value from before the load. The accumulator can be read as a 32-bit low word and an 8-bit high field, and it can be written through the same split.

Top module: `mac_dual_src`

## Requirements
- R1: While rst_n is low, the accumulator and all four kernel registers clear to zero. They read back as zero after reset is released.
- R2: Opcode 1 (signed multiply) writes the signed 16x16 product of the two selected halves, sign-extended to 40 bits, into the accumulator on the next clock edge.
- R3: Opcode 4 (unsigned multiply) multiplies the halves as unsigned numbers and writes the zero-extended product to the accumulator. It always uses gr_a and gr_b, whatever the source selects say.
- R4: Opcode 2 adds the signed product to the accumulator. The sum wraps modulo 2^40.
- R5: Opcode 3 subtracts the signed product from the accumulator. The difference wraps modulo 2^40.
- R6: With a_from_k low, the first operand is gr_a. With it high, the first operand is K0 (a_k_pick=0) or K1 (a_k_pick=1). The second operand follows the same rule with gr_b, K2 (b_k_pick=0) and K3 (b_k_pick=1). A take_hi bit of 1 picks bits 31:16 of the operand word, and 0 picks bits 15:0.
- R7: Opcode 5 (load) drives mem_rd=1 and mem_addr=ld_addr in the same cycle and writes mem_rdata into K[ld_dst] at the clock edge. It also drives addr_wb=1 with addr_next = ld_addr+4 when ld_dec=0, or ld_addr-4 when ld_dec=1. The accumulator does not change.
- R8: Opcode 6 (combined) adds the signed product to the accumulator and performs the load of R7 in the same command. Its first operand always comes from the kernel bank, even when a_from_k is low. If the load targets a register that the multiply reads, the product uses the value from before the load.
- R9: Opcode 7 replaces accumulator bits 31:0 with gr_b and keeps bits 39:32. Opcode 8 replaces bits 39:32 with gr_b[7:0] and keeps bits 31:0.
- R10: When cmd_valid is low, or the opcode is 0 or any value above 8, the accumulator and kernel registers keep their values and mem_rd and addr_wb stay low.
- R11: k_rd_data shows K[k_rd_sel] combinationally, and acc_lo/acc_hi show accumulator bits 31:0 and 39:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Opcode (0 none, 1 mul, 2 mac, 3 msub, 4 umul, 5 load, 6 mac+load, 7 write low, 8 write high) |
| a_from_k | input | 1 | First operand taken from K0/K1 |
| a_k_pick | input | 1 | First operand: 0 selects K0, 1 selects K1 |
| a_take_hi | input | 1 | First operand uses bits 31:16 |
| b_from_k | input | 1 | Second operand taken from K2/K3 |
| b_k_pick | input | 1 | Second operand: 0 selects K2, 1 selects K3 |
| b_take_hi | input | 1 | Second operand uses bits 31:16 |
| gr_a | input | 32 | First general-register operand |
| gr_b | input | 32 | Second general-register operand, also accumulator write data |
| ld_dst | input | 2 | Kernel register written by a load |
| ld_dec | input | 1 | Load steps the address down instead of up |
| ld_addr | input | 32 | Address register value for a load |
| mem_rdata | input | 32 | Read data returned in the same cycle |
| k_rd_sel | input | 2 | Kernel register shown on k_rd_data |
| mem_rd | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| addr_next | output | 32 | Stepped address for write-back |
| addr_wb | output | 1 | addr_next is valid |
| k_rd_data | output | 32 | Selected kernel register contents |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 8 | Accumulator bits 39:32 |

## Verification
A wrong source or half select, or a wrong signedness choice, shows up as a bad accumulator value one edge after the multiply command. A load that lands in the wrong kernel register stays hidden until a later multiply reads that register or the register is read back, so the bench reads all four registers after every burst of loads. A wrong carry into bits 39:32 appears only when the accumulator wraps or crosses the 32-bit boundary, which is why the bench preloads values near those boundaries. A read-before-write error in the combined command corrupts that one product, and the error surfaces at the next edge.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [3:0] {
      MC_NOP    = 4'd0,
      MC_MUL    = 4'd1,
      MC_MULA   = 4'd2,
      MC_MULS   = 4'd3,
      MC_UMUL   = 4'd4,
      MC_LOAD   = 4'd5,
      MC_MULA_LD= 4'd6,
      MC_WR_LO  = 4'd7,
      MC_WR_HI  = 4'd8
   } mac_cmd_e;

   typedef enum logic [1:0] {
      ACC_HOLD = 2'd0,
      ACC_SET  = 2'd1,
      ACC_ADD  = 2'd2,
      ACC_SUB  = 2'd3
   } acc_act_e;

   typedef struct packed {
      acc_act_e act;
      logic     is_uns;
      logic     a_to_gen;
      logic     a_to_k;
      logic     b_to_gen;
      logic     do_load;
      logic     wr_lo;
      logic     wr_hi;
   } mac_ctl_t;

   function automatic mac_ctl_t mac_decode(input logic valid, input mac_cmd_e c);
      mac_ctl_t t;
      t.act      = ACC_HOLD;
      t.is_uns   = 1'b0;
      t.a_to_gen = 1'b0;
      t.a_to_k   = 1'b0;
      t.b_to_gen = 1'b0;
      t.do_load  = 1'b0;
      t.wr_lo    = 1'b0;
      t.wr_hi    = 1'b0;
      if (valid) begin
         case (c)
            MC_MUL:  t.act = ACC_SET;
            MC_MULA: t.act = ACC_ADD;
            MC_MULS: t.act = ACC_SUB;
            MC_UMUL: begin
               t.act      = ACC_SET;
               t.is_uns   = 1'b1;
               t.a_to_gen = 1'b1;
               t.b_to_gen = 1'b1;
            end
            MC_LOAD: t.do_load = 1'b1;
            MC_MULA_LD: begin
               t.act     = ACC_ADD;
               t.a_to_k  = 1'b1;
               t.do_load = 1'b1;
            end
            MC_WR_LO: t.wr_lo = 1'b1;
            MC_WR_HI: t.wr_hi = 1'b1;
            default: ;
         endcase
      end
      return t;
   endfunction

endpackage

// File: rtl/mac_kbank.sv
module mac_kbank #(
   parameter int DW   = 32,
   parameter int NREG = 4,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [DW-1:0]             wr_data,
   output logic [NREG-1:0][DW-1:0]   regs
);

   if (NREG < 2) begin : g_bad_nreg
      $error("mac_kbank: NREG must be at least 2");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            q <= wr_data;
         end
      end
      assign regs[g] = q;
   end

endmodule

// File: rtl/mac_opnd_sel.sv
module mac_opnd_sel #(
   parameter int DW = 32,
   parameter int HW = 16
) (
   input  logic [DW-1:0] gen_word,
   input  logic [DW-1:0] k_even,
   input  logic [DW-1:0] k_odd,
   input  logic          from_k,
   input  logic          k_pick,
   input  logic          take_hi,
   output logic [HW-1:0] half
);

   if (DW != 2 * HW) begin : g_bad_split
      $error("mac_opnd_sel: DW must be twice HW");
   end

   logic [DW-1:0] word;

   always_comb begin
      if (!from_k)     word = gen_word;
      else if (k_pick) word = k_odd;
      else             word = k_even;
   end

   assign half = take_hi ? word[DW-1:HW] : word[HW-1:0];

endmodule

// File: rtl/mac_mul.sv
module mac_mul #(
   parameter int HW        = 16,
   parameter int ACC_W     = 40,
   parameter int MUL_STYLE = 0,
   localparam int PW       = 2 * HW + 2
) (
   input  logic [HW-1:0]    a,
   input  logic [HW-1:0]    b,
   input  logic             uns,
   output logic [ACC_W-1:0] prod
);

   if (ACC_W <= PW) begin : g_bad_acc
      $error("mac_mul: ACC_W must exceed 2*HW+2");
   end
   if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_style
      $error("mac_mul: MUL_STYLE must be 0 or 1");
   end

   logic [HW:0]   a_x;
   logic [HW:0]   b_x;
   logic [PW-1:0] p;

   assign a_x = {(uns ? 1'b0 : a[HW-1]), a};
   assign b_x = {(uns ? 1'b0 : b[HW-1]), b};

   if (MUL_STYLE == 0) begin : g_op
      logic signed [PW-1:0] ps;
      assign ps = $signed(a_x) * $signed(b_x);
      assign p  = ps;
   end else begin : g_shift_add
      logic [PW-1:0] a_wide;
      assign a_wide = {{(PW-HW-1){a_x[HW]}}, a_x};
      always_comb begin
         p = '0;
         for (int i = 0; i <= HW; i++) begin
            if (b_x[i]) begin
               if (i == HW) p = p - (a_wide << i);
               else         p = p + (a_wide << i);
            end
         end
      end
   end

   assign prod = {{(ACC_W-PW){p[PW-1]}}, p};

endmodule

// File: rtl/mac_acc.sv
module mac_acc
   import mac_pkg::*;
#(
   parameter int DW    = 32,
   parameter int ACC_W = 40,
   localparam int HI_W = ACC_W - DW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  acc_act_e         act,
   input  logic [ACC_W-1:0] prod,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [DW-1:0]    wr_lo_data,
   input  logic [HI_W-1:0]  wr_hi_data,
   output logic [ACC_W-1:0] acc
);

   if (HI_W < 1) begin : g_bad_hi
      $error("mac_acc: ACC_W must exceed DW");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
      end else begin
         case (act)
            ACC_SET: acc <= prod;
            ACC_ADD: acc <= acc + prod;
            ACC_SUB: acc <= acc - prod;
            default: ;
         endcase
         if (wr_lo) acc[DW-1:0]     <= wr_lo_data;
         if (wr_hi) acc[ACC_W-1:DW] <= wr_hi_data;
      end
   end

endmodule

// File: rtl/mac_dual_src.sv
module mac_dual_src
   import mac_pkg::*;
#(
   parameter int DW        = 32,
   parameter int HW        = 16,
   parameter int ACC_W     = 40,
   parameter int STEP      = 4,
   parameter int MUL_STYLE = 0,
   localparam int NK       = 4,
   localparam int KI_W     = 2,
   localparam int HI_W     = ACC_W - DW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic [3:0]      cmd_op,
   input  logic            a_from_k,
   input  logic            a_k_pick,
   input  logic            a_take_hi,
   input  logic            b_from_k,
   input  logic            b_k_pick,
   input  logic            b_take_hi,
   input  logic [DW-1:0]   gr_a,
   input  logic [DW-1:0]   gr_b,
   input  logic [KI_W-1:0] ld_dst,
   input  logic            ld_dec,
   input  logic [DW-1:0]   ld_addr,
   input  logic [DW-1:0]   mem_rdata,
   input  logic [KI_W-1:0] k_rd_sel,
   output logic            mem_rd,
   output logic [DW-1:0]   mem_addr,
   output logic [DW-1:0]   addr_next,
   output logic            addr_wb,
   output logic [DW-1:0]   k_rd_data,
   output logic [DW-1:0]   acc_lo,
   output logic [HI_W-1:0] acc_hi
);

   if (STEP <= 0) begin : g_bad_step
      $error("mac_dual_src: STEP must be positive");
   end
   if (HI_W > DW) begin : g_bad_hiw
      $error("mac_dual_src: high accumulator field wider than a word");
   end

   localparam logic [DW-1:0] STEP_W = DW'(STEP);

   mac_ctl_t              ctl;
   logic [NK-1:0][DW-1:0] kregs;
   logic                  a_src_k;
   logic                  b_src_k;
   logic [HW-1:0]         half_a;
   logic [HW-1:0]         half_b;
   logic [ACC_W-1:0]      prod;
   logic [ACC_W-1:0]      acc;

   assign ctl     = mac_decode(cmd_valid, mac_cmd_e'(cmd_op));
   assign a_src_k = ctl.a_to_k | (a_from_k & ~ctl.a_to_gen);
   assign b_src_k = b_from_k & ~ctl.b_to_gen;

   mac_opnd_sel #(.DW(DW), .HW(HW)) u_sel_a (
      .gen_word (gr_a),
      .k_even   (kregs[0]),
      .k_odd    (kregs[1]),
      .from_k   (a_src_k),
      .k_pick   (a_k_pick),
      .take_hi  (a_take_hi),
      .half     (half_a)
   );

   mac_opnd_sel #(.DW(DW), .HW(HW)) u_sel_b (
      .gen_word (gr_b),
      .k_even   (kregs[2]),
      .k_odd    (kregs[3]),
      .from_k   (b_src_k),
      .k_pick   (b_k_pick),
      .take_hi  (b_take_hi),
      .half     (half_b)
   );

   mac_mul #(.HW(HW), .ACC_W(ACC_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a    (half_a),
      .b    (half_b),
      .uns  (ctl.is_uns),
      .prod (prod)
   );

   mac_acc #(.DW(DW), .ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .act        (ctl.act),
      .prod       (prod),
      .wr_lo      (ctl.wr_lo),
      .wr_hi      (ctl.wr_hi),
      .wr_lo_data (gr_b),
      .wr_hi_data (gr_b[HI_W-1:0]),
      .acc        (acc)
   );

   mac_kbank #(.DW(DW), .NREG(NK)) u_kbank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctl.do_load),
      .wr_idx  (ld_dst),
      .wr_data (mem_rdata),
      .regs    (kregs)
   );

   assign mem_rd    = ctl.do_load;
   assign mem_addr  = ld_addr;
   assign addr_wb   = ctl.do_load;
   assign addr_next = ld_dec ? (ld_addr - STEP_W) : (ld_addr + STEP_W);
   assign k_rd_data = kregs[k_rd_sel];
   assign acc_lo    = acc[DW-1:0];
   assign acc_hi    = acc[ACC_W-1:DW];

endmodule

// File: rtl/mac_dual_src_chk.sv
module mac_dual_src_chk #(
   parameter int DW   = 32,
   parameter int HI_W = 8,
   parameter int STEP = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_valid,
   input logic [3:0]      cmd_op,
   input logic [DW-1:0]   gr_b,
   input logic [1:0]      ld_dst,
   input logic            ld_dec,
   input logic [DW-1:0]   ld_addr,
   input logic [DW-1:0]   mem_rdata,
   input logic [1:0]      k_rd_sel,
   input logic            mem_rd,
   input logic [DW-1:0]   mem_addr,
   input logic [DW-1:0]   addr_next,
   input logic            addr_wb,
   input logic [DW-1:0]   k_rd_data,
   input logic [DW-1:0]   acc_lo,
   input logic [HI_W-1:0] acc_hi
);

   localparam logic [DW-1:0] STEP_W = DW'(STEP);

   logic is_load;
   assign is_load = cmd_valid && (cmd_op == 4'd5 || cmd_op == 4'd6);

   p_load_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |-> (mem_rd && addr_wb && mem_addr == ld_addr));

   p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      addr_wb |-> ((ld_dec ? (ld_addr - addr_next) : (addr_next - ld_addr)) == STEP_W));

   p_load_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      is_load |=> ((k_rd_sel != $past(ld_dst)) || (k_rd_data == $past(mem_rdata))));

   p_load_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 4'd5) |=> (acc_lo == $past(acc_lo) && acc_hi == $past(acc_hi)));

   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (!mem_rd && !addr_wb));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> (acc_lo == $past(acc_lo) && acc_hi == $past(acc_hi)));

   p_wr_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 4'd7) |=> (acc_lo == $past(gr_b) && acc_hi == $past(acc_hi)));

   p_wr_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 4'd8) |=> (acc_hi == $past(gr_b[HI_W-1:0]) && acc_lo == $past(acc_lo)));

endmodule

bind mac_dual_src mac_dual_src_chk #(.DW(DW), .HI_W(HI_W), .STEP(STEP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .gr_b      (gr_b),
   .ld_dst    (ld_dst),
   .ld_dec    (ld_dec),
   .ld_addr   (ld_addr),
   .mem_rdata (mem_rdata),
   .k_rd_sel  (k_rd_sel),
   .mem_rd    (mem_rd),
   .mem_addr  (mem_addr),
   .addr_next (addr_next),
   .addr_wb   (addr_wb),
   .k_rd_data (k_rd_data),
   .acc_lo    (acc_lo),
   .acc_hi    (acc_hi)
);

// File: tb/mac_dual_src_bench.sv
`timescale 1ns/1ps
module mac_dual_src_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = '0;
   logic        a_from_k = 1'b0, a_k_pick = 1'b0, a_take_hi = 1'b0;
   logic        b_from_k = 1'b0, b_k_pick = 1'b0, b_take_hi = 1'b0;
   logic [31:0] gr_a = '0, gr_b = '0;
   logic [1:0]  ld_dst = '0;
   logic        ld_dec = 1'b0;
   logic [31:0] ld_addr = '0;
   logic [31:0] mem_rdata;
   logic [1:0]  k_rd_sel = '0;
   logic        mem_rd;
   logic [31:0] mem_addr;
   logic [31:0] addr_next;
   logic        addr_wb;
   logic [31:0] k_rd_data;
   logic [31:0] acc_lo;
   logic [7:0]  acc_hi;

   always #10 clk = ~clk;

   function automatic logic [31:0] memf(input logic [31:0] a);
      return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
   endfunction

   assign mem_rdata = memf(mem_addr);

   mac_dual_src u_mac_dual_src (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .a_from_k(a_from_k), .a_k_pick(a_k_pick), .a_take_hi(a_take_hi),
      .b_from_k(b_from_k), .b_k_pick(b_k_pick), .b_take_hi(b_take_hi),
      .gr_a(gr_a), .gr_b(gr_b), .ld_dst(ld_dst), .ld_dec(ld_dec),
      .ld_addr(ld_addr), .mem_rdata(mem_rdata), .k_rd_sel(k_rd_sel),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .addr_next(addr_next),
      .addr_wb(addr_wb), .k_rd_data(k_rd_data), .acc_lo(acc_lo), .acc_hi(acc_hi)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [39:0] m_acc = '0;
   logic [31:0] m_k [4] = '{default: '0};

   typedef struct {
      logic [39:0] acc;
      string       tag;
   } exp_t;
   exp_t q[$];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [39:0] mprod(input logic [15:0] a, input logic [15:0] b, input bit u);
      logic signed [31:0] sp;
      logic [31:0] up;
      if (u) begin
         up = a * b;
         return {8'h00, up};
      end
      sp = $signed(a) * $signed(b);
      return {{8{sp[31]}}, sp};
   endfunction

   // Driver: applies one command, checks same-cycle outputs, queues expected accumulator.
   task automatic issue(input logic [3:0] op, input bit afk, input bit apk, input bit ahi,
                        input bit bfk, input bit bpk, input bit bhi,
                        input logic [31:0] ga, input logic [31:0] gb,
                        input logic [1:0] dst, input bit dec, input logic [31:0] addr,
                        input string tag);
      bit ak, bk, load, u;
      logic [31:0] wa, wb, exp_next;
      logic [15:0] ha, hb;
      logic [39:0] p;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op;
      a_from_k = afk; a_k_pick = apk; a_take_hi = ahi;
      b_from_k = bfk; b_k_pick = bpk; b_take_hi = bhi;
      gr_a = ga; gr_b = gb; ld_dst = dst; ld_dec = dec; ld_addr = addr;
      u    = (op == 4'd4);
      ak   = (op == 4'd4) ? 1'b0 : (op == 4'd6) ? 1'b1 : afk;
      bk   = (op == 4'd4) ? 1'b0 : bfk;
      load = (op == 4'd5) || (op == 4'd6);
      wa = ak ? m_k[apk ? 1 : 0] : ga;
      wb = bk ? m_k[bpk ? 3 : 2] : gb;
      ha = ahi ? wa[31:16] : wa[15:0];
      hb = bhi ? wb[31:16] : wb[15:0];
      p  = mprod(ha, hb, u);
      case (op)
         4'd1, 4'd4: m_acc = p;
         4'd2, 4'd6: m_acc = m_acc + p;
         4'd3:       m_acc = m_acc - p;
         4'd7:       m_acc[31:0]  = gb;
         4'd8:       m_acc[39:32] = gb[7:0];
         default: ;
      endcase
      #1;
      chk(mem_rd == load, {tag, " mem_rd R7 R10"}, 64'(mem_rd), 64'(load));
      chk(addr_wb == load, {tag, " addr_wb R7 R10"}, 64'(addr_wb), 64'(load));
      if (load) begin
         exp_next = dec ? addr - 32'd4 : addr + 32'd4;
         chk(addr_next == exp_next, {tag, " addr_next R7"}, 64'(addr_next), 64'(exp_next));
         chk(mem_addr == addr, {tag, " mem_addr R7"}, 64'(mem_addr), 64'(addr));
         m_k[dst] = memf(addr);
      end
      q.push_back('{acc: m_acc, tag: tag});
   endtask

   task automatic idle();
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic check_k(input int i, input string tag);
      @(negedge clk);
      cmd_valid = 1'b0;
      k_rd_sel = 2'(i);
      #1;
      chk(k_rd_data == m_k[i], $sformatf("%s K%0d R11", tag, i), 64'(k_rd_data), 64'(m_k[i]));
   endtask

   task automatic check_all_k(input string tag);
      for (int i = 0; i < 4; i++) check_k(i, tag);
   endtask

   task automatic expect_acc(input logic [39:0] v, input string tag);
      @(negedge clk);
      cmd_valid = 1'b0;
      #1;
      chk({acc_hi, acc_lo} == v, tag, 64'({acc_hi, acc_lo}), 64'(v));
   endtask

   // Monitor: compares the accumulator a quarter period after each edge.
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #5;
         if (q.size() > 0) begin
            e = q.pop_front();
            chk({acc_hi, acc_lo} == e.acc, {e.tag, " acc"}, 64'({acc_hi, acc_lo}), 64'(e.acc));
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk({acc_hi, acc_lo} == 40'h0, "reset acc R1", 64'({acc_hi, acc_lo}), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      check_all_k("reset R1");

      // R9 split writes
      issue(4'd7, 0,0,0, 0,0,0, 32'h0, 32'h1234_5678, 0, 0, 0, "wr_lo R9");
      issue(4'd8, 0,0,0, 0,0,0, 32'h0, 32'hFFFF_FFAB, 0, 0, 0, "wr_hi R9");
      expect_acc(40'hAB_1234_5678, "split write value R9");

      // R3: unsigned, source selects ignored
      issue(4'd4, 1,1,0, 1,1,0, 32'h0000_FFFF, 32'h0000_FFFF, 0, 0, 0, "umul R3");
      expect_acc(40'h00_FFFE_0001, "umul value R3");

      // R2 / R6: signed, high half of b
      issue(4'd1, 0,0,0, 0,0,1, 32'h0000_FFFF, 32'h0002_7777, 0, 0, 0, "mul signed R2 R6");
      expect_acc(40'hFF_FFFF_FFFE, "mul value R2");

      // R7 loads, increment and decrement
      issue(4'd5, 0,0,0, 0,0,0, 0, 0, 2'd0, 0, 32'h0000_0100, "load K0 inc R7");
      issue(4'd5, 0,0,0, 0,0,0, 0, 0, 2'd2, 1, 32'h0000_0200, "load K2 dec R7");
      issue(4'd5, 0,0,0, 0,0,0, 0, 0, 2'd1, 0, 32'h0000_0FFC, "load K1 R7");
      issue(4'd5, 0,0,0, 0,0,0, 0, 0, 2'd3, 1, 32'h0000_0000, "load K3 wrap R7");
      check_all_k("after loads R7");

      // R6 / R4 / R5 with kernel sources
      issue(4'd1, 1,1,1, 1,1,0, 0, 0, 0, 0, 0, "mul K1hi*K3lo R6");
      issue(4'd2, 1,0,1, 1,1,0, 0, 0, 0, 0, 0, "mula K0hi*K3lo R4 R6");
      issue(4'd3, 0,0,0, 1,0,1, 32'h0000_8000, 0, 0, 0, 0, "muls gen*K2hi R5 R6");
      issue(4'd2, 1,0,0, 0,0,0, 0, 32'h8000_0000, 0, 0, 0, "mula K0lo*gen R4 R6");

      // R4 / R5 wrap at 2^40
      issue(4'd8, 0,0,0, 0,0,0, 0, 32'h0000_00FF, 0, 0, 0, "wr_hi FF R9");
      issue(4'd7, 0,0,0, 0,0,0, 0, 32'hFFFF_FFFF, 0, 0, 0, "wr_lo FF R9");
      issue(4'd2, 0,0,0, 0,0,0, 32'h1, 32'h1, 0, 0, 0, "mula wrap R4");
      expect_acc(40'h0, "wrap up to zero R4");
      issue(4'd3, 0,0,0, 0,0,0, 32'h1, 32'h1, 0, 0, 0, "muls wrap R5");
      expect_acc(40'hFF_FFFF_FFFF, "wrap down R5");

      // R8 combined, same register read and loaded; a_from_k low must be overridden
      issue(4'd6, 0,0,0, 0,0,0, 32'h7FFF_7FFF, 32'h0000_0003, 2'd0, 0, 32'h0000_0040, "mula_ld same reg R8");
      issue(4'd6, 0,1,1, 1,0,0, 0, 0, 2'd2, 1, 32'h0000_0080, "mula_ld K/K R8");
      check_all_k("after combined R8");

      // R10 no-effect commands
      issue(4'd0, 1,1,1, 1,1,1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 0, 32'h10, "nop op0 R10");
      issue(4'd9, 1,1,1, 1,1,1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd1, 0, 32'h10, "op9 ignored R10");
      issue(4'd15, 0,0,0, 0,0,0, 32'h1234, 32'h5678, 2'd3, 1, 32'h20, "op15 ignored R10");
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'd2; gr_a = 32'h7FFF; gr_b = 32'h7FFF;
      #1;
      chk(mem_rd == 1'b0, "invalid cmd mem_rd R10", 64'(mem_rd), 64'h0);
      q.push_back('{acc: m_acc, tag: "invalid cmd hold R10"});
      @(negedge clk);
      cmd_op = 4'd5;
      #1;
      chk(addr_wb == 1'b0, "invalid load addr_wb R10", 64'(addr_wb), 64'h0);
      check_all_k("after ignored R10");

      // Mixed random sequence against the model
      for (int n = 0; n < 80; n++) begin
         logic [31:0] r;
         r = $urandom;
         issue(4'($urandom_range(0, 9)), r[0], r[1], r[2], r[3], r[4], r[5],
               $urandom, $urandom, r[7:6], r[8], {20'h0, r[19:9], 1'b0} << 1,
               "random R2 R4 R5 R6 R7 R8");
         if (n % 10 == 9) check_all_k("random R11");
      end
      idle();
      idle();
      idle();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule